// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block is a single, non-pipelined arithmetic engine that multiplies or divides two integer operands, either signed (two's complement) or unsigned, at a width of 32 or 64 bits. A requester raises `req_valid` with the operands and the operation selects. The unit takes the request on a rising clock edge where it is idle. It then keeps `busy` high while it works, and raises `done` for one cycle when the result words are ready.

A multiply always takes the same number of cycles for a given width. A multiply yields a double-width product split into a high and a low word. A divide yields the quotient in the low word and the remainder in the high word. A divide runs one quotient bit per cycle, and only over the quotient bit positions that can be non-zero. Those positions are found from the operands' leading-zero counts before the iteration starts, so divide latency follows the size of the result. Division by zero finishes at the shortest divide latency and raises a flag.

Top module: `imdu_top`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. From the next cycle `busy` is 1, and it stays 1 until the cycle in which `done` is 1, where `busy` is 0.
- R2: A request raised while `busy` is 1 is dropped. It produces no `done` of its own and does not change the result or the timing of the operation in progress.
- R3: With `req_wide`=0 and `req_div`=0, `done` is 1 in the cycle that follows the 4th rising edge after the accepting edge.
- R4: With `req_wide`=1 and `req_div`=0, `done` is 1 in the cycle that follows the 6th rising edge after the accepting edge.
- R5: A multiply returns the full double-width product, with the upper half in `res_hi` and the lower half in `res_lo`. `req_signed`=1 treats both operands as two's complement, and 0 treats them as unsigned.
- R6: A divide returns in `res_lo` the quotient truncated toward zero and in `res_hi` the remainder. The remainder carries the sign of the dividend.
- R7: Let S be 0 when the dividend magnitude is 0 or has more leading zeros than the divisor magnitude (counted over 64 bits). Otherwise S is lz(divisor) - lz(dividend) + 1. A non-zero divide then takes max(21, 9 + S) edges from the accepting edge to `done`, which gives a range of 21 to 73.
- R8: A divide by zero takes 21 edges and sets `div_zero` to 1. The quotient is all ones, and the remainder is the dividend.
- R9: With `req_wide`=0, only bits 31:0 of each operand are used, and bits 63:32 of each result word repeat its bit 31. A zero divisor is one whose bits 31:0 are zero.
- R10: After reset, `busy`, `done`, `div_zero`, `res_hi` and `res_lo` are 0. `done` lasts one cycle. The result words and the flag change only together with `done` and hold their value until the next `done`.
- R11: `div_zero` is 0 after any multiply and after any divide by a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operation request |
| req_div | input | 1 | 1 = divide, 0 = multiply |
| req_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| req_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| req_a | input | 64 | Multiplicand or dividend |
| req_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in progress; new requests are dropped |
| done | output | 1 | One-cycle pulse marking fresh results |
| div_zero | output | 1 | Last completed operation divided by zero |
| res_hi | output | 64 | Product high word or remainder |
| res_lo | output | 64 | Product low word or quotient |

## Verification
Every result has a due time that follows from the request alone. A multiply is due 4 or 6 edges after acceptance. A divide is due at max(21, 9 + S) edges, with S computed in the bench from the leading zeros of the operand magnitudes, and a zero divisor is due at 21 edges. The driver stamps each accepted request with the number of its accepting edge and queues the expected words, flag and due edge. The monitor samples on falling edges. When `done` is seen, it compares the edge count at that moment with the stamp plus the due latency. This catches a result that arrives early, late or unrequested, and catches `busy` dropping before its result arrives.

// File: rtl/imdu_pkg.sv
// Package for the multiply-divide unit: sequencer states shared by the
// top module. Assumes nothing beyond IEEE 1800-2017 enum support.
package imdu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a request
        ST_MUL   = 3'd1,  // accumulating multiplier digits
        ST_SETUP = 3'd2,  // leading-zero analysis for a divide
        ST_DIV   = 3'd3,  // one quotient bit per cycle
        ST_FIX   = 3'd4,  // sign correction and width formatting
        ST_HOLD  = 3'd5   // pad to the promised latency
    } seq_state_t;

endpackage

// File: rtl/imdu_lzc.sv
// Leading-zero counter. Returns the number of zero bits above the most
// significant one; returns W for an all-zero input. Purely combinational.
module imdu_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [CW-1:0] zeros
);

    // Scan upward so that the highest set bit decides the count.
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (value[i]) begin
                zeros = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/imdu_mul_step.sv
// One multiply iteration: picks digit number idx (CHUNK bits) of the
// multiplier, multiplies it by the full multiplicand and adds the partial
// product, shifted into place, to the running accumulator.
// Assumes unsigned magnitudes and W a multiple of CHUNK.
module imdu_mul_step #(
    parameter int W     = 64,
    parameter int CHUNK = 16,
    parameter int IW    = 2
) (
    input  logic [2*W-1:0] acc_in,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    input  logic [IW-1:0]  idx,
    output logic [2*W-1:0] acc_out
);

    localparam int PW = W + CHUNK;

    logic [CHUNK-1:0] digit;
    logic [PW-1:0]    part;
    logic [2*W-1:0]   placed;

    // Form the shifted partial product and add it to the accumulator.
    always_comb begin
        digit   = mplier[idx*CHUNK +: CHUNK];
        part    = {{CHUNK{1'b0}}, mcand} * {{W{1'b0}}, digit};
        placed  = {{(2*W-PW){1'b0}}, part} << (idx * CHUNK);
        acc_out = acc_in + placed;
    end

endmodule

// File: rtl/imdu_div_step.sv
// One restoring-division iteration with a pre-aligned divisor: if the
// aligned divisor fits in the partial remainder it is subtracted and a one
// enters the quotient; the divisor then moves one place right.
// Assumes unsigned magnitudes and that the divisor was aligned without loss.
module imdu_div_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] dsr_in,
    input  logic [W-1:0] quo_in,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] dsr_out,
    output logic [W-1:0] quo_out
);

    logic fits;

    // Trial subtraction and quotient bit insertion.
    always_comb begin
        fits    = (dsr_in <= rem_in);
        rem_out = fits ? (rem_in - dsr_in) : rem_in;
        quo_out = {quo_in[W-2:0], fits};
        dsr_out = dsr_in >> 1;
    end

endmodule

// File: rtl/imdu_top.sv
// Iterative integer multiply-divide unit. Takes one operation at a time
// (valid while not busy), works on unsigned magnitudes and applies the
// signs at the end. Multiply latency is fixed per width; divide latency
// is max(DIV_FLOOR, DIV_BASE + quotient bit positions). Narrow results
// are sign-extended from bit NARROW-1. Assumes XLEN and NARROW are
// multiples of MUL_CHUNK and that reset is held across at least one edge.
module imdu_top
    import imdu_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NARROW    = 32,
    parameter int MUL_CHUNK = 16,
    parameter int DIV_BASE  = 9,
    parameter int DIV_FLOOR = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_div,
    input  logic            req_signed,
    input  logic            req_wide,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    output logic            busy,
    output logic            done,
    output logic            div_zero,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);

    localparam int LZW        = $clog2(XLEN + 1);
    localparam int CNT_W      = $clog2(DIV_BASE + XLEN + 2);
    localparam int STEPS_WIDE = XLEN / MUL_CHUNK;
    localparam int STEPS_NAR  = NARROW / MUL_CHUNK;
    localparam int STEP_W     = (STEPS_WIDE > 1) ? $clog2(STEPS_WIDE) : 1;
    localparam int EXT_W      = XLEN - NARROW;
    localparam logic [CNT_W-1:0] LAT_MUL_WIDE = CNT_W'(2 + STEPS_WIDE);
    localparam logic [CNT_W-1:0] LAT_MUL_NAR  = CNT_W'(2 + STEPS_NAR);
    localparam logic [CNT_W-1:0] LAT_FLOOR    = CNT_W'(DIV_FLOOR);

    seq_state_t        state;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [CNT_W-1:0]  target;
    logic              op_div;
    logic              op_wide;
    logic              neg_a;
    logic              neg_b;
    logic              dz_r;
    logic [XLEN-1:0]   mag_a;
    logic [XLEN-1:0]   mag_b;
    logic [2*XLEN-1:0] acc;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] last_step;
    logic [XLEN-1:0]   rem;
    logic [XLEN-1:0]   dsr;
    logic [XLEN-1:0]   quo;
    logic [LZW-1:0]    iter;
    logic [XLEN-1:0]   stage_hi;
    logic [XLEN-1:0]   stage_lo;

    // Issue-side operand shaping.
    logic [XLEN-1:0] ext_a;
    logic [XLEN-1:0] ext_b;
    logic            sgn_a;
    logic            sgn_b;
    logic            accept;

    // Widen narrow operands and find the operand signs.
    always_comb begin
        if (req_wide) begin
            ext_a = req_a;
            ext_b = req_b;
        end else if (req_signed) begin
            ext_a = {{EXT_W{req_a[NARROW-1]}}, req_a[NARROW-1:0]};
            ext_b = {{EXT_W{req_b[NARROW-1]}}, req_b[NARROW-1:0]};
        end else begin
            ext_a = {{EXT_W{1'b0}}, req_a[NARROW-1:0]};
            ext_b = {{EXT_W{1'b0}}, req_b[NARROW-1:0]};
        end
        sgn_a  = req_signed & ext_a[XLEN-1];
        sgn_b  = req_signed & ext_b[XLEN-1];
        accept = req_valid & (state == ST_IDLE);
    end

    assign busy = (state != ST_IDLE);

    // Iteration datapaths.
    logic [2*XLEN-1:0] acc_nxt;
    logic [XLEN-1:0]   rem_nxt;
    logic [XLEN-1:0]   dsr_nxt;
    logic [XLEN-1:0]   quo_nxt;
    logic [LZW-1:0]    lz_a;
    logic [LZW-1:0]    lz_b;

    imdu_mul_step #(.W(XLEN), .CHUNK(MUL_CHUNK), .IW(STEP_W)) mul_step_i (
        .acc_in  (acc),
        .mcand   (mag_a),
        .mplier  (mag_b),
        .idx     (step),
        .acc_out (acc_nxt)
    );

    imdu_div_step #(.W(XLEN)) div_step_i (
        .rem_in  (rem),
        .dsr_in  (dsr),
        .quo_in  (quo),
        .rem_out (rem_nxt),
        .dsr_out (dsr_nxt),
        .quo_out (quo_nxt)
    );

    imdu_lzc #(.W(XLEN), .CW(LZW)) lzc_a_i (
        .value (mag_a),
        .zeros (lz_a)
    );

    imdu_lzc #(.W(XLEN), .CW(LZW)) lzc_b_i (
        .value (mag_b),
        .zeros (lz_b)
    );

    // Divide setup: quotient bit count, divisor alignment, due latency.
    logic [LZW-1:0]   lz_gap;
    logic [LZW-1:0]   sig_bits;
    logic [CNT_W-1:0] div_sum;
    logic [CNT_W-1:0] div_due;
    logic             zero_dsr;

    // Derive the iteration count and the divide latency from leading zeros.
    always_comb begin
        zero_dsr = (mag_b == '0);
        lz_gap   = lz_b - lz_a;
        if (zero_dsr || (mag_a == '0) || (lz_a > lz_b)) begin
            sig_bits = '0;
        end else begin
            sig_bits = lz_gap + LZW'(1);
        end
        div_sum = CNT_W'(DIV_BASE) + CNT_W'(sig_bits);
        div_due = (div_sum < LAT_FLOOR) ? LAT_FLOOR : div_sum;
    end

    // Final sign correction and width formatting.
    logic [2*XLEN-1:0] prod_signed;
    logic [XLEN-1:0]   raw_hi;
    logic [XLEN-1:0]   raw_lo;
    logic [XLEN-1:0]   fix_hi;
    logic [XLEN-1:0]   fix_lo;

    // Apply result signs, split the product and sign-extend narrow words.
    always_comb begin
        prod_signed = (neg_a ^ neg_b) ? (~acc + 1'b1) : acc;
        if (op_div) begin
            raw_lo = dz_r ? '1 : ((neg_a ^ neg_b) ? (~quo + 1'b1) : quo);
            raw_hi = neg_a ? (~rem + 1'b1) : rem;
        end else if (op_wide) begin
            raw_lo = prod_signed[XLEN-1:0];
            raw_hi = prod_signed[2*XLEN-1:XLEN];
        end else begin
            raw_lo = {{EXT_W{1'b0}}, prod_signed[NARROW-1:0]};
            raw_hi = {{EXT_W{1'b0}}, prod_signed[2*NARROW-1:NARROW]};
        end
        if (op_wide) begin
            fix_hi = raw_hi;
            fix_lo = raw_lo;
        end else begin
            fix_hi = {{EXT_W{raw_hi[NARROW-1]}}, raw_hi[NARROW-1:0]};
            fix_lo = {{EXT_W{raw_lo[NARROW-1]}}, raw_lo[NARROW-1:0]};
        end
    end

    // Sequencer: issue, iterate, correct signs, then release at the due edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cyc_cnt   <= '0;
            target    <= '0;
            op_div    <= 1'b0;
            op_wide   <= 1'b0;
            neg_a     <= 1'b0;
            neg_b     <= 1'b0;
            dz_r      <= 1'b0;
            mag_a     <= '0;
            mag_b     <= '0;
            acc       <= '0;
            step      <= '0;
            last_step <= '0;
            rem       <= '0;
            dsr       <= '0;
            quo       <= '0;
            iter      <= '0;
            stage_hi  <= '0;
            stage_lo  <= '0;
            done      <= 1'b0;
            div_zero  <= 1'b0;
            res_hi    <= '0;
            res_lo    <= '0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE) begin
                cyc_cnt <= cyc_cnt + CNT_W'(1);
            end
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cyc_cnt   <= CNT_W'(1);
                        op_div    <= req_div;
                        op_wide   <= req_wide;
                        neg_a     <= sgn_a;
                        neg_b     <= sgn_b;
                        mag_a     <= sgn_a ? (~ext_a + 1'b1) : ext_a;
                        mag_b     <= sgn_b ? (~ext_b + 1'b1) : ext_b;
                        acc       <= '0;
                        step      <= '0;
                        last_step <= req_wide ? STEP_W'(STEPS_WIDE - 1)
                                              : STEP_W'(STEPS_NAR - 1);
                        target    <= req_wide ? LAT_MUL_WIDE : LAT_MUL_NAR;
                        state     <= req_div ? ST_SETUP : ST_MUL;
                    end
                end
                ST_MUL: begin
                    acc  <= acc_nxt;
                    step <= step + STEP_W'(1);
                    if (step == last_step) begin
                        state <= ST_FIX;
                    end
                end
                ST_SETUP: begin
                    dz_r   <= zero_dsr;
                    rem    <= mag_a;
                    quo    <= '0;
                    dsr    <= mag_b << lz_gap;
                    iter   <= sig_bits;
                    target <= div_due;
                    state  <= (sig_bits == '0) ? ST_FIX : ST_DIV;
                end
                ST_DIV: begin
                    rem  <= rem_nxt;
                    dsr  <= dsr_nxt;
                    quo  <= quo_nxt;
                    iter <= iter - LZW'(1);
                    if (iter == LZW'(1)) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    stage_hi <= fix_hi;
                    stage_lo <= fix_lo;
                    state    <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (cyc_cnt == target) begin
                        res_hi   <= stage_hi;
                        res_lo   <= stage_lo;
                        div_zero <= op_div & dz_r;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/imdu_chk.sv
// Protocol checker for imdu_top, attached by bind. Watches the handshake,
// the done pulse, result stability and the latency window. Assumes the
// synchronous active-low reset of the checked block.
module imdu_chk #(
    parameter int XLEN    = 64,
    parameter int MIN_LAT = 4,
    parameter int MAX_LAT = 73
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            div_zero,
    input logic [XLEN-1:0] res_hi,
    input logic [XLEN-1:0] res_lo
);

    int unsigned edges_since_issue;

    // Count edges from the accepting edge while the unit is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_since_issue <= 0;
        end else if (req_valid && !busy) begin
            edges_since_issue <= 1;
        end else if (busy) begin
            edges_since_issue <= edges_since_issue + 1;
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_hi));

    // R10
    hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_lo));

    // R8
    hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(div_zero));

    // R7 (counter holds latency + 1 in the done cycle)
    latency_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edges_since_issue >= MIN_LAT + 1) && (edges_since_issue <= MAX_LAT + 1));

endmodule

bind imdu_top imdu_chk #(.XLEN(64), .MIN_LAT(4), .MAX_LAT(73)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
);

// File: tb/imdu_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for imdu_top: the driver queues expected results with
// their due edge, the monitor compares each done against the queue head.
module imdu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_div = 1'b0;
    logic        req_signed = 1'b0;
    logic        req_wide = 1'b0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic        busy;
    logic        done;
    logic        div_zero;
    logic [63:0] res_hi;
    logic [63:0] res_lo;

    int     checks = 0;
    int     errors = 0;
    int     issued = 0;
    int     dones  = 0;
    longint cyc    = 0;

    typedef struct {
        logic [63:0] hi;
        logic [63:0] lo;
        logic        dz;
        int          lat;
        longint      issue;
        string       res_tag;
        string       lat_tag;
    } exp_t;

    exp_t sbq[$];

    imdu_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_div    (req_div),
        .req_signed (req_signed),
        .req_wide   (req_wide),
        .req_a      (req_a),
        .req_b      (req_b),
        .busy       (busy),
        .done       (done),
        .div_zero   (div_zero),
        .res_hi     (res_hi),
        .res_lo     (res_lo)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic int lz64(input logic [63:0] v);
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) return 63 - i;
        end
        return 64;
    endfunction

    // Reference model written from the requirements.
    task automatic model(input bit dv, input bit sg, input bit wd,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] hi, output logic [63:0] lo,
                         output logic dz, output int lat);
        logic [63:0]  ae, be, ma, mb, q, r;
        logic [127:0] p;
        bit           na, nb;
        int           la, lb, sig;
        ae = wd ? a : (sg ? sx32(a) : {32'b0, a[31:0]});
        be = wd ? b : (sg ? sx32(b) : {32'b0, b[31:0]});
        dz = 1'b0;
        if (!dv) begin
            if (sg) p = $signed({{64{ae[63]}}, ae}) * $signed({{64{be[63]}}, be});
            else    p = {64'b0, ae} * {64'b0, be};
            if (wd) begin
                lo = p[63:0];
                hi = p[127:64];
            end else begin
                lo = sx32({32'b0, p[31:0]});
                hi = sx32({32'b0, p[63:32]});
            end
            lat = wd ? 6 : 4;
        end else if (be == 64'd0) begin
            dz  = 1'b1;
            lo  = '1;
            hi  = wd ? ae : sx32(ae);
            lat = 21;
        end else begin
            na = sg && ae[63];
            nb = sg && be[63];
            ma = na ? -ae : ae;
            mb = nb ? -be : be;
            q  = ma / mb;
            r  = ma % mb;
            if (na ^ nb) q = -q;
            if (na) r = -r;
            lo = wd ? q : sx32(q);
            hi = wd ? r : sx32(r);
            la = lz64(ma);
            lb = lz64(mb);
            sig = (ma == 0 || la > lb) ? 0 : (lb - la + 1);
            lat = (9 + sig < 21) ? 21 : 9 + sig;
        end
    endtask

    // Driver: wait for the unit to be free, raise one request, queue its result.
    task automatic issue(input bit dv, input bit sg, input bit wd,
                         input logic [63:0] a, input logic [63:0] b,
                         input string res_tag, input string lat_tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_div = dv; req_signed = sg; req_wide = wd; req_a = a; req_b = b;
        req_valid = 1'b1;
        model(dv, sg, wd, a, b, e.hi, e.lo, e.dz, e.lat);
        e.issue   = cyc + 1;
        e.res_tag = res_tag;
        e.lat_tag = lat_tag;
        sbq.push_back(e);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R1", "busy after accept", {63'b0, busy}, 64'd1);
    endtask

    // Monitor: compare every done against the oldest outstanding request.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                dones++;
                if (sbq.size() == 0) begin
                    check(1'b0, "R2", "unrequested done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(res_hi == e.hi, e.res_tag, "res_hi", res_hi, e.hi);
                    check(res_lo == e.lo, e.res_tag, "res_lo", res_lo, e.lo);
                    check(div_zero == e.dz, e.dz ? "R8" : "R11", "div_zero",
                          {63'b0, div_zero}, {63'b0, e.dz});
                    check(cyc - e.issue == longint'(e.lat), e.lat_tag, "latency",
                          64'(cyc - e.issue), 64'(e.lat));
                end
            end else if (sbq.size() > 0 && cyc >= sbq[0].issue && !busy) begin
                check(1'b0, "R1", "busy low before done", 64'd0, 64'd1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, %0d results outstanding", sbq.size());
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0, "R10", "busy after reset", {63'b0, busy}, 64'd0);
        check(done == 1'b0, "R10", "done after reset", {63'b0, done}, 64'd0);
        check(div_zero == 1'b0, "R10", "flag after reset", {63'b0, div_zero}, 64'd0);
        check(res_hi == 64'd0 && res_lo == 64'd0, "R10", "results after reset",
              res_hi | res_lo, 64'd0);

        // Multiplies (R3 narrow, R4 wide, R5 values, R9 narrow shaping)
        issue(0, 0, 0, 64'hAAAA_BBBB_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, "R9", "R3");
        issue(0, 1, 0, 64'h0000_0000_FFFF_FFFB, 64'h0000_0000_0000_0007, "R5", "R3");
        issue(0, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, "R5", "R3");
        issue(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5", "R4");
        issue(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 64'h7FFF_FFFF_0000_1234, "R5", "R4");
        issue(0, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5", "R4");

        // Divides (R6 values, R7 latency)
        issue(1, 0, 1, 64'd7, 64'd3, "R6", "R7");
        issue(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R6", "R7");
        issue(1, 0, 1, 64'h0000_0100_0000_0000, 64'd1, "R6", "R7");
        issue(1, 1, 1, -64'sd7, 64'd2, "R6", "R7");
        issue(1, 1, 1, 64'd7, -64'sd2, "R6", "R7");
        issue(1, 0, 1, 64'd3, 64'd7, "R6", "R7");
        issue(1, 0, 1, 64'd0, 64'd5, "R6", "R7");
        issue(1, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6", "R7");
        issue(1, 0, 0, 64'h5555_5555_FFFF_FFFF, 64'h9999_9999_0000_0001, "R9", "R7");
        issue(1, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R9", "R7");

        // Divide by zero (R8), including a narrow divisor with only high bits set (R9)
        issue(1, 1, 1, -64'sd9, 64'd0, "R8", "R8");
        issue(1, 0, 0, 64'h0000_0000_1234_5678, 64'h0000_0001_0000_0000, "R9", "R8");
        // R11: flag must clear again on the next multiply
        issue(0, 0, 1, 64'd12, 64'd11, "R11", "R4");

        // R2: requests raised while busy must be dropped
        issue(0, 0, 1, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0010, "R2", "R4");
        for (int k = 0; k < 3; k++) begin
            req_div = 1'b1; req_signed = 1'b0; req_wide = 1'b1;
            req_a = 64'd99 + 64'(k); req_b = 64'd0;
            req_valid = busy;
            @(negedge clk);
        end
        req_valid = 1'b0;

        while (sbq.size() > 0) @(negedge clk);
        repeat (80) @(negedge clk);
        // R2: exactly one done per accepted request
        check(dones == issued, "R2", "done count", 64'(dones), 64'(issued));
        check(res_lo == 64'h0000_0000_0010_0000, "R2", "result after dropped requests",
              res_lo, 64'h0000_0000_0010_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule